// File: doc/BRIEF.md
# Cache-Blocked Memory Op Replay Queue

This block parks memory operations that the data cache turned away and offers them to the issue stage again once the cache says it can take requests. Each parked operation is identified by a tag. When the cache signals that it has unblocked, every parked tag moves, oldest first, behind any tags already waiting for replay. The replay list is then drained one tag per cycle. The operations are replayed where they are, with no pipeline squash and no refetch. If a replayed operation is refused again, its tag is simply pushed back into the parked list.

The issue output has a fixed slot layout that also gives the priority order. Slot 0 carries a deferred-translation operation whose translation has finished or which was squashed. Slot 1 carries the replayed operation. Slots 2 and up carry normal ready operations, packed lowest candidate index first. Neither replay slot uses up the normal issue width. An activity output tells the core whether there is work in flight, and a sticky flag records a push that was dropped because the shared storage was full.

Top module: `mem_replay_queue`

## Requirements
- R1: An accepted block push appends its tag to the parked list. One cycle later `clr_valid` pulses with the same tag, which tells the core to clear that operation's translation-started, translation-done, issued and can-issue flags.
- R2: An `unblock` pulse moves every parked tag, in arrival order, onto the tail of the replay list, and `wake` pulses one cycle later.
- R3: A block push in the same cycle as `unblock` is part of that move and replays after all tags that were parked before it.
- R4: Slot 1 (`iss_valid[1]`) issues the oldest replay-list tag, one per cycle, starting two cycles after the unblock pulse. It stays low while the replay list is empty.
- R5: A parked tag is never issued before an unblock pulse has moved it.
- R6: A replayed tag that is pushed again is parked again, and replays only after the next unblock pulse, in its new arrival order.
- R7: A `dfr_valid` input with its tag appears on slot 0 (`iss_valid[0]`) one cycle later, whatever else is issued in that cycle.
- R8: Of the `N_READY` normal candidates, the first `ISSUE_W` valid ones in ascending index order appear one cycle later on slots 2 to `ISSUE_W`+1, with no gaps. This count is not reduced when slots 0 or 1 are in use.
- R9: `activity` is high one cycle after any cycle with a deferred op ready, a deferred op pending (`dfr_pending`), a non-empty replay list, or any valid normal candidate. Otherwise it is low.
- R10: A push made while parked plus replay entries equal `DEPTH` is dropped: it produces no `clr_valid` and never replays. `overflow` then goes high and stays high until reset.
- R11: Reset empties both lists, clears `overflow`, and drives every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_push_valid | input | 1 | Memory op was refused by the cache; park it |
| blk_push_tag | input | TAG_W | Tag of the refused op |
| unblock | input | 1 | Cache can accept requests again (pulse) |
| dfr_valid | input | 1 | A deferred-translation op is ready this cycle |
| dfr_tag | input | TAG_W | Tag of that deferred op |
| dfr_pending | input | 1 | Deferred-translation list is not empty |
| norm_valid | input | N_READY | Normal ready candidates |
| norm_tag | input | N_READY*TAG_W | Candidate tags, candidate i at bits i*TAG_W |
| iss_valid | output | ISSUE_W+2 | Issue slot valids: 0 deferred, 1 replay, 2.. normal |
| iss_tag | output | (ISSUE_W+2)*TAG_W | Issue slot tags, slot k at bits k*TAG_W |
| clr_valid | output | 1 | Clear-flags notice for an accepted push |
| clr_tag | output | TAG_W | Tag whose flags are to be cleared |
| wake | output | 1 | Wake-the-core pulse after an unblock |
| activity | output | 1 | Work issued or waiting |
| overflow | output | 1 | Sticky: a push was dropped while storage was full |

## Verification
The assertions check these on every cycle: the clear-flags echo of each push, the one-cycle wake response to an unblock, the one-cycle pass-through on the deferred slot, the exact number of packed normal slots, activity whenever a replay issues, and that overflow stays set. Behaviours that depend on list contents over many cycles can only be shown by the bench scenarios. These are replay order across a move, the same-cycle push and unblock, re-parking a refused replay, holding parked tags until an unblock, dropping a push at full occupancy, and reset emptying the lists. The bench checks them with a scoreboard of expected replay tags.

// File: rtl/mrq_pkg.sv
package mrq_pkg;
  localparam int SLOT_DFR = 0;
  localparam int SLOT_RTY = 1;
  localparam int SLOT_NRM = 2;
endpackage

// File: rtl/replay_ring.sv
module replay_ring #(
  parameter int TAG_W = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_valid,
  input  logic [TAG_W-1:0] push_tag,
  input  logic             unblock,
  output logic             rty_valid,
  output logic [TAG_W-1:0] rty_tag,
  output logic             rty_nonempty,
  output logic             clr_valid,
  output logic [TAG_W-1:0] clr_tag,
  output logic             wake,
  output logic             overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  // One circular store: [rd, split) is the replay list, [split, wr) is parked.
  logic [TAG_W-1:0] mem [DEPTH];
  logic [PW-1:0]    rd_ptr, split_ptr, wr_ptr;
  logic [PW-1:0]    occ, wr_next;
  logic             full, push_ok;

  assign occ          = wr_ptr - rd_ptr;
  assign full         = (occ == PW'(DEPTH));
  assign push_ok      = push_valid & ~full;
  assign rty_nonempty = (rd_ptr != split_ptr);
  assign wr_next      = wr_ptr + PW'(push_ok);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr[AW-1:0]] <= push_tag;
  end

  always_ff @(posedge clk) begin
    if (rty_nonempty) rty_tag <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr    <= '0;
      split_ptr <= '0;
      wr_ptr    <= '0;
      rty_valid <= 1'b0;
      clr_valid <= 1'b0;
      clr_tag   <= '0;
      wake      <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      wr_ptr    <= wr_next;
      if (rty_nonempty) rd_ptr <= rd_ptr + PW'(1);
      if (unblock) split_ptr <= wr_next;
      rty_valid <= rty_nonempty;
      clr_valid <= push_ok;
      clr_tag   <= push_tag;
      wake      <= unblock;
      if (push_valid && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/ready_compact.sv
module ready_compact #(
  parameter int TAG_W  = 8,
  parameter int N_IN   = 8,
  parameter int N_OUT  = 4
) (
  input  logic [N_IN-1:0]        in_valid,
  input  logic [N_IN*TAG_W-1:0]  in_tag,
  output logic [N_OUT-1:0]       out_valid,
  output logic [N_OUT*TAG_W-1:0] out_tag
);
  always_comb begin
    int rank;
    out_valid = '0;
    out_tag   = '0;
    rank      = 0;
    for (int i = 0; i < N_IN; i++) begin
      if (in_valid[i]) begin
        for (int k = 0; k < N_OUT; k++) begin
          if (rank == k) begin
            out_valid[k] = 1'b1;
            out_tag[k*TAG_W +: TAG_W] = in_tag[i*TAG_W +: TAG_W];
          end
        end
        rank = rank + 1;
      end
    end
  end
endmodule

// File: rtl/mem_replay_queue.sv
module mem_replay_queue
  import mrq_pkg::*;
#(
  parameter int TAG_W   = 8,
  parameter int DEPTH   = 16,
  parameter int ISSUE_W = 4,
  parameter int N_READY = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         blk_push_valid,
  input  logic [TAG_W-1:0]             blk_push_tag,
  input  logic                         unblock,
  input  logic                         dfr_valid,
  input  logic [TAG_W-1:0]             dfr_tag,
  input  logic                         dfr_pending,
  input  logic [N_READY-1:0]           norm_valid,
  input  logic [N_READY*TAG_W-1:0]     norm_tag,
  output logic [ISSUE_W+1:0]           iss_valid,
  output logic [(ISSUE_W+2)*TAG_W-1:0] iss_tag,
  output logic                         clr_valid,
  output logic [TAG_W-1:0]             clr_tag,
  output logic                         wake,
  output logic                         activity,
  output logic                         overflow
);
  localparam int SLOTS = ISSUE_W + 2;

  logic             rty_valid, rty_nonempty;
  logic [TAG_W-1:0] rty_tag;
  logic [ISSUE_W-1:0]       cmp_valid;
  logic [ISSUE_W*TAG_W-1:0] cmp_tag;
  logic                     dfr_v_q;
  logic [TAG_W-1:0]         dfr_t_q;
  logic [ISSUE_W-1:0]       nrm_v_q;
  logic [ISSUE_W*TAG_W-1:0] nrm_t_q;

  replay_ring #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst(rst),
    .push_valid(blk_push_valid), .push_tag(blk_push_tag),
    .unblock(unblock),
    .rty_valid(rty_valid), .rty_tag(rty_tag), .rty_nonempty(rty_nonempty),
    .clr_valid(clr_valid), .clr_tag(clr_tag),
    .wake(wake), .overflow(overflow)
  );

  ready_compact #(.TAG_W(TAG_W), .N_IN(N_READY), .N_OUT(ISSUE_W)) u_cmp (
    .in_valid(norm_valid), .in_tag(norm_tag),
    .out_valid(cmp_valid), .out_tag(cmp_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dfr_v_q  <= 1'b0;
      dfr_t_q  <= '0;
      nrm_v_q  <= '0;
      nrm_t_q  <= '0;
      activity <= 1'b0;
    end else begin
      dfr_v_q  <= dfr_valid;
      dfr_t_q  <= dfr_tag;
      nrm_v_q  <= cmp_valid;
      nrm_t_q  <= cmp_tag;
      activity <= dfr_valid | dfr_pending | rty_nonempty | (|norm_valid);
    end
  end

  always_comb begin
    iss_valid = '0;
    iss_tag   = '0;
    iss_valid[SLOT_DFR] = dfr_v_q;
    iss_tag[SLOT_DFR*TAG_W +: TAG_W] = dfr_t_q;
    iss_valid[SLOT_RTY] = rty_valid;
    iss_tag[SLOT_RTY*TAG_W +: TAG_W] = rty_valid ? rty_tag : '0;
    iss_valid[SLOTS-1:SLOT_NRM] = nrm_v_q;
    iss_tag[SLOTS*TAG_W-1:SLOT_NRM*TAG_W] = nrm_t_q;
  end
endmodule

// File: rtl/mem_replay_queue_checker.sv
module mem_replay_queue_checker #(
  parameter int TAG_W   = 8,
  parameter int ISSUE_W = 4,
  parameter int N_READY = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               blk_push_valid,
  input logic [TAG_W-1:0]   blk_push_tag,
  input logic               unblock,
  input logic               dfr_valid,
  input logic [N_READY-1:0] norm_valid,
  input logic [ISSUE_W+1:0] iss_valid,
  input logic               clr_valid,
  input logic [TAG_W-1:0]   clr_tag,
  input logic               wake,
  input logic               activity,
  input logic               overflow
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_clr_echo_R1: assert property (@(posedge clk) disable iff (rst || !past_ok)
    clr_valid |-> ($past(blk_push_valid) && clr_tag == $past(blk_push_tag)));

  assert_wake_on_unblock_R2: assert property (@(posedge clk) disable iff (rst)
    unblock |=> wake);

  assert_no_spurious_wake_R2: assert property (@(posedge clk) disable iff (rst)
    !unblock |=> !wake);

  assert_dfr_slot_R7: assert property (@(posedge clk) disable iff (rst)
    dfr_valid |=> iss_valid[0]);

  assert_dfr_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !dfr_valid |=> !iss_valid[0]);

  assert_norm_count_R8: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $countones(iss_valid[ISSUE_W+1:2]) ==
      (($countones($past(norm_valid)) > ISSUE_W) ? ISSUE_W : $countones($past(norm_valid))));

  assert_replay_activity_R9: assert property (@(posedge clk) disable iff (rst)
    iss_valid[1] |-> activity);

  assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

bind mem_replay_queue mem_replay_queue_checker #(
  .TAG_W(TAG_W), .ISSUE_W(ISSUE_W), .N_READY(N_READY)
) u_chk (
  .clk(clk), .rst(rst),
  .blk_push_valid(blk_push_valid), .blk_push_tag(blk_push_tag),
  .unblock(unblock), .dfr_valid(dfr_valid), .norm_valid(norm_valid),
  .iss_valid(iss_valid), .clr_valid(clr_valid), .clr_tag(clr_tag),
  .wake(wake), .activity(activity), .overflow(overflow)
);

// File: tb/tb_mem_replay_queue.sv
`timescale 1ns/1ps
module tb_mem_replay_queue;
  localparam int TAG_W = 8, DEPTH = 16, ISSUE_W = 4, N_READY = 8;
  localparam int SLOTS = ISSUE_W + 2;

  logic clk = 1'b0, rst = 1'b1;
  logic blk_push_valid = 0, unblock = 0, dfr_valid = 0, dfr_pending = 0;
  logic [TAG_W-1:0] blk_push_tag = '0, dfr_tag = '0;
  logic [N_READY-1:0] norm_valid = '0;
  logic [N_READY*TAG_W-1:0] norm_tag;
  logic [SLOTS-1:0] iss_valid;
  logic [SLOTS*TAG_W-1:0] iss_tag;
  logic clr_valid, wake, activity, overflow;
  logic [TAG_W-1:0] clr_tag;

  int n_chk = 0, n_fail = 0;
  logic [TAG_W-1:0] exp_q[$];

  always #4 clk = ~clk;

  mem_replay_queue #(.TAG_W(TAG_W), .DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .N_READY(N_READY)) dut (
    .clk(clk), .rst(rst), .blk_push_valid(blk_push_valid), .blk_push_tag(blk_push_tag),
    .unblock(unblock), .dfr_valid(dfr_valid), .dfr_tag(dfr_tag), .dfr_pending(dfr_pending),
    .norm_valid(norm_valid), .norm_tag(norm_tag), .iss_valid(iss_valid), .iss_tag(iss_tag),
    .clr_valid(clr_valid), .clr_tag(clr_tag), .wake(wake), .activity(activity),
    .overflow(overflow));

  initial for (int i = 0; i < N_READY; i++) norm_tag[i*TAG_W +: TAG_W] = TAG_W'(8'h40 + i);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [TAG_W-1:0] slot_tag(input int k);
    return iss_tag[k*TAG_W +: TAG_W];
  endfunction

  // Scoreboard monitor for the replay slot (R4, R5).
  always @(negedge clk) begin
    if (!rst && iss_valid[1]) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected replay", {24'b0, slot_tag(1)}, 32'h0);
      end else begin
        logic [TAG_W-1:0] e;
        e = exp_q.pop_front();
        chk(slot_tag(1) == e, "R4 replay order", {24'b0, slot_tag(1)}, {24'b0, e});
      end
    end
  end

  task automatic push(input logic [TAG_W-1:0] t);
    blk_push_valid = 1; blk_push_tag = t;
    tick();
    blk_push_valid = 0;
    chk(clr_valid && clr_tag == t, "R1 clear notice", {23'b0, clr_valid, clr_tag}, {23'b0, 1'b1, t});
  endtask

  task automatic drain();
    for (int i = 0; i < 60 && exp_q.size() > 0; i++) tick();
    tick(); tick();
    chk(exp_q.size() == 0, "R4 scoreboard empty", exp_q.size(), 0);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=%0d expected=0", wd);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) tick();
    chk(iss_valid == '0 && !clr_valid && !wake && !activity && !overflow, "R11 reset outputs",
        {26'b0, iss_valid}, 0);
    rst = 0;
    tick();

    // R1, R5: park three tags, nothing replays
    push(8'hA0); push(8'hA1); push(8'hA2);
    repeat (4) tick();
    chk(!iss_valid[1], "R5 parked held", iss_valid[1], 0);

    // R2: unblock moves all in order
    unblock = 1; exp_q.push_back(8'hA0); exp_q.push_back(8'hA1); exp_q.push_back(8'hA2);
    tick(); unblock = 0;
    chk(wake, "R2 wake pulse", wake, 1);
    tick();
    chk(activity, "R9 activity with replay pending", activity, 1);
    chk(!wake, "R2 wake single pulse", wake, 0);
    drain();

    // R3: push and unblock in the same cycle
    blk_push_valid = 1; blk_push_tag = 8'hB3; unblock = 1; exp_q.push_back(8'hB3);
    tick(); blk_push_valid = 0; unblock = 0;
    chk(clr_valid && clr_tag == 8'hB3, "R3 same-cycle push accepted", clr_tag, 8'hB3);
    drain();

    // R6: refused replay re-parked, behind a newer tag
    push(8'hE0); push(8'hA0);
    repeat (3) tick();
    chk(!iss_valid[1], "R6 re-parked held", iss_valid[1], 0);
    unblock = 1; exp_q.push_back(8'hE0); exp_q.push_back(8'hA0);
    tick(); unblock = 0;
    drain();

    // R7, R8: deferred slot and full normal width
    dfr_valid = 1; dfr_tag = 8'h77; norm_valid = 8'hFF;
    tick();
    chk(iss_valid[0] && slot_tag(0) == 8'h77, "R7 deferred slot", slot_tag(0), 8'h77);
    chk(iss_valid[5:2] == 4'hF && slot_tag(2) == 8'h40 && slot_tag(5) == 8'h43,
        "R8 full width lowest first", {slot_tag(2), slot_tag(5)}, 16'h4043);
    dfr_valid = 0; norm_valid = 8'b1010_0110;
    tick();
    chk(!iss_valid[0], "R7 deferred idle", iss_valid[0], 0);
    chk(slot_tag(2) == 8'h41 && slot_tag(3) == 8'h42 && slot_tag(4) == 8'h45 && slot_tag(5) == 8'h47,
        "R8 sparse compaction", {slot_tag(2), slot_tag(3), slot_tag(4), slot_tag(5)}, 32'h41424547);
    norm_valid = 8'h01;
    tick();
    chk(iss_valid[5:2] == 4'b0001 && slot_tag(2) == 8'h40, "R8 single candidate",
        {28'b0, iss_valid[5:2]}, 1);
    norm_valid = '0;

    // R8: replay and deferred do not eat the normal budget
    push(8'hF1);
    unblock = 1; exp_q.push_back(8'hF1);
    tick(); unblock = 0;
    dfr_valid = 1; dfr_tag = 8'h78; norm_valid = 8'hFF;
    tick();
    chk(iss_valid == 6'b111111, "R8 width kept with replay", {26'b0, iss_valid}, 32'h3F);
    dfr_valid = 0; norm_valid = '0;
    drain();

    // R9: idle activity low, pending deferred raises it
    tick();
    chk(!activity, "R9 idle activity", activity, 0);
    dfr_pending = 1; tick(); dfr_pending = 0;
    chk(activity, "R9 deferred pending", activity, 1);

    // R10: overflow drop
    for (int i = 0; i < DEPTH; i++) push(TAG_W'(8'h80 + i));
    blk_push_valid = 1; blk_push_tag = 8'hEE;
    tick(); blk_push_valid = 0;
    chk(!clr_valid, "R10 dropped push no clear", clr_valid, 0);
    chk(overflow, "R10 overflow raised", overflow, 1);
    unblock = 1;
    for (int i = 0; i < DEPTH; i++) exp_q.push_back(TAG_W'(8'h80 + i));
    tick(); unblock = 0;
    drain();
    chk(overflow, "R10 overflow sticky", overflow, 1);

    // R11: reset empties lists and clears overflow
    push(8'h11); push(8'h12);
    rst = 1; tick(); rst = 0;
    chk(!overflow && iss_valid == '0, "R11 reset clears", {31'b0, overflow}, 0);
    unblock = 1; tick(); unblock = 0;
    repeat (3) tick();
    chk(!iss_valid[1], "R11 nothing left to replay", iss_valid[1], 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule